// File: doc/BRIEF.md
# Double-Buffered Serial Bit Transmitter

This block turns parallel words into a serial bit stream for an SPI-style data line. It sends one bit per system clock, most significant bit first. A producer offers a word on a valid/ready input. The word is taken at the clock edge where both valid and ready are high. Serial clock generation, chip select and the receive side belong to neighbouring logic.

There are two places a word can be. One is the shift register that drives the line. The other is a single holding slot in front of it. While a word is shifting and the slot is empty, ready stays high, so a second word can be queued. The queued word starts shifting in the cycle after the previous word's last bit, so transmission has no idle gap. An active flag is high in every cycle that carries a data bit.

Back-pressure rules:
- Ready is low only while the holding slot is full.
- Valid may be a one-cycle pulse; the word only has to be valid in the cycle it is taken.
- A word offered while ready is low is dropped. It is not held or retried, and it changes neither stored word.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After the active-low reset, in_ready is 1, tx_active is 0 and tx_bit is 0.
- R2: A word taken at an edge (in_valid and in_ready both high) while the line is idle appears on tx_bit from the next cycle, bit W-1 first and bit 0 last, one bit per cycle; for example, 8'b11100010 gives 1,1,1,0,0,0,1,0.
- R3: For a single word with nothing queued, tx_active is high for exactly W consecutive cycles and then returns to 0.
- R4: While a word is shifting and the holding slot is empty, in_ready stays 1 and a new word is accepted into the slot, including during the first bit period.
- R5: In the cycle after a word enters the holding slot, in_ready goes to 0. It stays 0 until the queued word's first bit is on tx_bit, and is 1 in that cycle.
- R6: A queued word starts on tx_bit in the cycle right after the previous word's last bit. tx_active stays high across the word boundary.
- R7: A word offered while in_ready is 0 is ignored. The word in the shift register and the queued word both go out unchanged, and nothing extra is sent afterwards.
- R8: tx_bit is 0 in every cycle where tx_active is 0.
- R9: A word taken in the same cycle as the last bit of the current word, with the slot empty, goes straight to the shift register. Its first bit follows with no gap, and in_ready stays 1.
- R10: After the last queued word finishes, tx_active falls to 0 and in_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bit is sent per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered on in_data |
| in_ready | output | 1 | High when the holding slot is empty and a word can be taken |
| in_data | input | W | Parallel word to send |
| tx_bit | output | 1 | Serial data line |
| tx_active | output | 1 | High in every cycle that carries a data bit |

## Verification
The bench targets the word boundary in three ways:
- Queueing during the first bit period. A design whose ready falls too early or too late shows the wrong in_ready on those cycles.
- Queueing late in a word.
- Offering a word in the exact cycle of the last bit. A design that inserts an idle cycle there drops tx_active for one cycle between words.

It also offers a word while the slot is full. A design that lets this through either sends a third word or sends corrupted bits for the queued one. The bench also checks the idle line after every transfer. This catches a shift register that is not cleared, which would leave a stale 1 on tx_bit.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  // Source of the word loaded into the shift register this cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SLOT  = 2'd1,
    SRC_INPUT = 2'd2
  } load_src_e;

endpackage

// File: rtl/sbt_holdslot.sv
module sbt_holdslot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] data_o,
  output logic         full_o
);

  logic [W-1:0] word_q;
  logic         full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      word_q <= wr_data;
      full_q <= 1'b1;
    end else if (rd_en) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = word_q;
  assign full_o = full_q;

  // R7: the controller never writes over a queued word
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_o);

  // R6: the slot is only drained when it holds a word
  assert_drain_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> full_o);

endmodule

// File: rtl/sbt_shifter.sv
module sbt_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         bit_o,
  output logic         busy_o,
  output logic         last_o
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] idx_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= load_data_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        sh_q   <= '0;
        idx_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[W-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign bit_o  = sh_q[W-1];
  assign busy_o = busy_q;
  assign last_o = busy_q && (idx_q == LAST_IDX);

  // R8: the line rests low whenever no word is shifting
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bit_o);

  // R3: a word is never cut short before its final bit
  assert_no_midword_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> busy_o);

endmodule

// File: rtl/sbt_loadsel.sv
module sbt_loadsel
  import sbt_pkg::*;
(
  input  logic      busy_i,
  input  logic      last_i,
  input  logic      slot_full_i,
  input  logic      take_i,
  output load_src_e src_o,
  output logic      slot_wr_o,
  output logic      slot_rd_o
);

  logic free;

  always_comb begin
    free      = !busy_i || last_i;
    src_o     = SRC_NONE;
    slot_wr_o = 1'b0;
    slot_rd_o = 1'b0;
    if (free) begin
      if (slot_full_i) begin
        src_o     = SRC_SLOT;
        slot_rd_o = 1'b1;
      end else if (take_i) begin
        src_o = SRC_INPUT;
      end
    end else begin
      slot_wr_o = take_i;
    end
  end

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import sbt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         tx_bit,
  output logic         tx_active
);

  logic         slot_full, slot_wr, slot_rd;
  logic [W-1:0] slot_data;
  logic         busy, last, take, load;
  logic [W-1:0] load_data;
  load_src_e    src;

  assign in_ready = !slot_full;
  assign take     = in_valid && in_ready;

  sbt_loadsel u_sel (
    .busy_i      (busy),
    .last_i      (last),
    .slot_full_i (slot_full),
    .take_i      (take),
    .src_o       (src),
    .slot_wr_o   (slot_wr),
    .slot_rd_o   (slot_rd)
  );

  sbt_holdslot #(.W(W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_wr),
    .wr_data (in_data),
    .rd_en   (slot_rd),
    .data_o  (slot_data),
    .full_o  (slot_full)
  );

  assign load      = (src != SRC_NONE);
  assign load_data = (src == SRC_SLOT) ? slot_data : in_data;

  sbt_shifter #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_data_i (load_data),
    .bit_o       (tx_bit),
    .busy_o      (busy),
    .last_o      (last)
  );

  assign tx_active = busy;

  // R2: a word taken on an idle line starts shifting next cycle
  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tx_active) |=> tx_active);

  // R5: queueing behind a shifting word closes the input next cycle
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tx_active && !last) |=> !in_ready);

  // R6: a queued word follows the last bit without a gap
  assert_gapless_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && slot_full) |=> (tx_active && in_ready));

  // R9: a word taken on the last bit continues the stream directly
  assert_direct_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && take && !slot_full) |=> (tx_active && in_ready));

endmodule

// File: tb/serial_tx_dbuf_tb_top.sv
module serial_tx_dbuf_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, tx_bit, tx_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_tx_dbuf #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .tx_bit    (tx_bit),
    .tx_active (tx_active)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // advance to just after the next rising edge
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // check the line, active flag and ready for one cycle
  task automatic expect_cycle(input string req, input int b, input int act, input int rdy);
    check(req, "tx_bit", int'(tx_bit), b);
    check(req, "tx_active", int'(tx_active), act);
    check(req, "in_ready", int'(in_ready), rdy);
  endtask

  task automatic expect_idle(input string req);
    expect_cycle(req, 0, 0, 1);
  endtask

  task automatic t_reset();
    expect_idle("R1");
  endtask

  task automatic t_single(input logic [W-1:0] w);
    in_valid = 1'b1; in_data = w;
    cyc();
    in_valid = 1'b0; in_data = '0;
    for (int i = W - 1; i >= 0; i--) begin
      expect_cycle("R2", int'(w[i]), 1, 1);
      cyc();
    end
    expect_idle("R3");
    cyc();
    expect_idle("R8");
  endtask

  // queue a second word at bit position q (1 = first bit period)
  task automatic t_queue(input logic [W-1:0] a, input logic [W-1:0] b, input int q);
    in_valid = 1'b1; in_data = a;
    cyc();
    in_valid = 1'b0;
    for (int k = 1; k <= W; k++) begin
      if (k == q) begin
        in_valid = 1'b1; in_data = b;
      end
      expect_cycle(k <= q ? "R4" : "R5", int'(a[W-k]), 1, (k <= q) ? 1 : 0);
      cyc();
      in_valid = 1'b0; in_data = '0;
    end
    for (int k = 1; k <= W; k++) begin
      expect_cycle(k == 1 ? "R6" : "R5", int'(b[W-k]), 1, 1);
      cyc();
    end
    expect_idle("R10");
    cyc();
  endtask

  // offer a third word while the slot is full
  task automatic t_ignored(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    in_valid = 1'b1; in_data = a;
    cyc();
    in_data = b;
    for (int k = 1; k <= W; k++) begin
      if (k >= 2) in_data = c;
      expect_cycle("R7", int'(a[W-k]), 1, (k == 1) ? 1 : 0);
      cyc();
    end
    in_valid = 1'b0; in_data = '0;
    for (int k = 1; k <= W; k++) begin
      expect_cycle("R7", int'(b[W-k]), 1, 1);
      cyc();
    end
    expect_idle("R7");
    cyc();
    expect_idle("R7");
  endtask

  // offer a word in the cycle of the last bit, slot empty
  task automatic t_coincident(input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = 1'b1; in_data = a;
    cyc();
    in_valid = 1'b0;
    for (int k = 1; k <= W; k++) begin
      if (k == W) begin
        in_valid = 1'b1; in_data = b;
      end
      expect_cycle("R9", int'(a[W-k]), 1, 1);
      cyc();
      in_valid = 1'b0; in_data = '0;
    end
    for (int k = 1; k <= W; k++) begin
      expect_cycle("R9", int'(b[W-k]), 1, 1);
      cyc();
    end
    expect_idle("R10");
    cyc();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    expect_idle("R1");
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_single(8'b11100010);
    t_single(8'b00011101);
    t_single(8'b10000001);
    t_queue(8'b11100010, 8'b00011101, 1);
    t_queue(8'b01010101, 8'b10101010, 5);
    t_queue(8'b11111111, 8'b00000001, W - 1);
    t_ignored(8'b11001100, 8'b00110011, 8'b11111111);
    t_coincident(8'b10110010, 8'b01001101);
    expect_idle("R8");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule